// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block turns a stereo serial audio stream into parallel words. The stream has a bit clock, a frame clock and a data line. The bit clock, frame clock and data arrive asynchronously to the system clock. The block synchronizes all three and detects rising bit-clock edges. It samples data and frame clock on those edges and finds the half-frame boundaries from changes of the frame clock.

Three framings are accepted:
- **Left-justified:** the word starts on the boundary and is treated as a full 24-bit word.
- **I2S:** the word starts one bit later and is treated as a full 24-bit word.
- **Right-justified:** the word ends on the last bit before the next boundary. Only a programmed number of trailing bits (16, 20 or 24) is kept.

Words are delivered MSB-aligned in a 24-bit field. Discarded or absent low bits read as zero, because no dither is added. Once the right word of a pair is complete, the left and right words are presented together with a one-cycle valid pulse.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, left_o and right_o are zero and valid_o is low.
- R2: With fmt_i = 2'b00 (left-justified), the bit sampled on the first rising bit-clock edge after a frame-clock change is the word MSB (bit 23). Frame clock high marks the left channel.
- R3: With fmt_i = 2'b01 (I2S), the word MSB is the bit sampled on the second rising bit-clock edge after a frame-clock change. Frame clock low marks the left channel.
- R4: In left-justified and I2S framings, bits past the 24th in a half-frame are ignored.
- R5: In left-justified and I2S framings, a half-frame with fewer than 24 bit clocks yields a word whose missing low bits are zero.
- R6: With fmt_i[1] = 1 (right-justified), only the last N bits before the next frame-clock change are kept. N is 16 for res_i = 0, 20 for res_i = 1, and 24 for res_i = 2 or 3. They are placed in bits 23 down to 24-N, and bits below are zero.
- R7: In right-justified framing, a half-frame shorter than N bits yields zeros in the kept field positions that received no bit.
- R8: valid_o pulses for exactly one cycle per completed left/right pair, after the right half-frame ends. left_o and right_o hold their values between pulses.
- R9: A half-frame that was already in progress at reset release is never output. A right word with no preceding complete left word produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Frame clock selecting channel (asynchronous) |
| sd_i | input | 1 | Serial data, MSB first (asynchronous) |
| fmt_i | input | 2 | Framing: 00 left-justified, 01 I2S, 1x right-justified |
| res_i | input | 2 | Right-justified resolution: 0=16, 1=20, 2/3=24 bits |
| left_o | output | 24 | Left word, MSB-aligned |
| right_o | output | 24 | Right word, MSB-aligned |
| valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The embedded properties watch several things on every cycle:
- the single-cycle width of valid_o and its tie to a bit-clock edge;
- the zeroed low byte of 16-bit right-justified words;
- the restart of the bit count at each boundary;
- the frame toggle at a boundary.

The correct bit alignment of each framing (R2, R3) can only be shown by the bench's scenarios. The same holds for dropping excess bits (R4), zero-filling short half-frames (R5), selecting the trailing N bits (R6, R7) and suppressing the partial first half-frame (R9). Those scenarios compare each output pair against words computed from the transmitted pattern.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned RES_A  = 16;
  localparam int unsigned RES_B  = 20;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RJ2 = 2'b11
  } fmt_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_frame.sv
module sar_frame (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic lrck_s_i,
  input  logic i2s_i,
  output logic rise_o,
  output logic start_o,
  output logic done_o,
  output logic done_left_o
);
  logic sck_q, lrck_prev_q, fs_q, seen_q, armed_q;
  logic fs;

  assign rise_o = sck_s_i & ~sck_q;
  // I2S: channel select lags one bit and is inverted, mapping it onto justified timing
  assign fs          = i2s_i ? ~lrck_prev_q : lrck_s_i;
  assign start_o     = rise_o & seen_q & (fs != fs_q);
  assign done_o      = start_o & armed_q;
  assign done_left_o = fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      lrck_prev_q <= 1'b0;
      fs_q        <= 1'b0;
      seen_q      <= 1'b0;
      armed_q     <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      if (rise_o) begin
        lrck_prev_q <= lrck_s_i;
        fs_q        <= fs;
        seen_q      <= 1'b1;
        if (start_o) armed_q <= 1'b1;
      end
    end
  end

  p_rise_isolated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  p_start_flips_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (fs_q != $past(fs_q)) && armed_q);
endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
  parameter int unsigned WORD_W = sar_pkg::WORD_W,
  parameter int unsigned RES_A  = sar_pkg::RES_A,
  parameter int unsigned RES_B  = sar_pkg::RES_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              start_i,
  input  logic              sd_i,
  input  logic              rj_i,
  input  logic [1:0]        res_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam int unsigned SH_A  = WORD_W - RES_A;
  localparam int unsigned SH_B  = WORD_W - RES_B;

  logic [WORD_W-1:0] acc_q, acc_n, sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] rj_word;

  always_comb begin
    acc_n = acc_q;
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (start_i) begin
      acc_n             = '0;
      acc_n[WORD_W-1]   = sd_i;
      sh_n              = {{(WORD_W-1){1'b0}}, sd_i};
      cnt_n             = CNT_W'(1);
    end else begin
      for (int i = 0; i < WORD_W; i++) begin
        if (cnt_q == CNT_W'(WORD_W - 1 - i)) acc_n[i] = sd_i;
      end
      sh_n = {sh_q[WORD_W-2:0], sd_i};
      if (cnt_q != CNT_W'(WORD_W)) cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      acc_q <= acc_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  always_comb begin
    unique case (res_i)
      2'd0:    rj_word = sh_q << SH_A;
      2'd1:    rj_word = sh_q << SH_B;
      default: rj_word = sh_q;
    endcase
  end

  assign word_o = rj_i ? rj_word : acc_q;

  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && start_i) |=> cnt_q == CNT_W'(1));
  p_cnt_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int unsigned WORD_W      = sar_pkg::WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              lrck_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        res_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  import sar_pkg::*;

  localparam int unsigned LOW_A = WORD_W - RES_A;

  logic [2:0] raw, syn;
  logic rise, start, done, done_left;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] lhold_q;
  logic lhv_q;
  logic rj, i2s;

  assign raw = {sd_i, lrck_i, sck_i};
  assign rj  = fmt_i[1];
  assign i2s = (fmt_e'(fmt_i) == FMT_I2S);

  sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  sar_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (syn[0]),
    .lrck_s_i   (syn[1]),
    .i2s_i      (i2s),
    .rise_o     (rise),
    .start_o    (start),
    .done_o     (done),
    .done_left_o(done_left)
  );

  sar_capture #(.WORD_W(WORD_W)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .start_i(start),
    .sd_i   (syn[2]),
    .rj_i   (rj),
    .res_i  (res_i),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lhold_q <= '0;
      lhv_q   <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done && done_left) begin
        lhold_q <= word;
        lhv_q   <= 1'b1;
      end else if (done && lhv_q) begin
        left_o  <= lhold_q;
        right_o <= word;
        valid_o <= 1'b1;
        lhv_q   <= 1'b0;
      end
    end
  end

  p_valid_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_valid_after_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise));
  p_hold_between_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !$past(valid_o) |-> $stable(left_o) && $stable(right_o));
  p_rj16_low_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rj && res_i == 2'd0) |->
      (left_o[LOW_A-1:0] == '0) && (right_o[LOW_A-1:0] == '0));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
  localparam int H = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni = 1'b0;
  logic sck = 1'b0, lrck = 1'b0, sd = 1'b0;
  logic [1:0] fmt = 2'b00, resv = 2'b00;
  logic [23:0] left_o, right_o;
  logic valid_o;

  serial_audio_rx i_serial_audio_rx (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .sck_i  (sck),
    .lrck_i (lrck),
    .sd_i   (sd),
    .fmt_i  (fmt),
    .res_i  (resv),
    .left_o (left_o),
    .right_o(right_o),
    .valid_o(valid_o)
  );

  int n_cmp = 0, n_bad = 0, hold_bad = 0;
  bit finished = 0;
  logic pend = 1'b0;
  logic [23:0] q_l[$], q_r[$];
  string q_tag[$];

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic [23:0] last_l = '0, last_r = '0;
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      last_l = '0; last_r = '0; prev_v = 1'b0;
    end else begin
      if (valid_o && prev_v) check(0, "R8 pulse width", 48'd2, 48'd1);
      if (valid_o) begin
        if (q_l.size() == 0) begin
          check(0, "R9 unexpected pair", {left_o, right_o}, 48'd0);
        end else begin
          logic [23:0] el, er;
          string t;
          el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
          check(left_o == el && right_o == er, t, {left_o, right_o}, {el, er});
        end
        last_l = left_o; last_r = right_o;
      end else if (left_o != last_l || right_o != last_r) begin
        hold_bad++;
      end
      prev_v = valid_o;
    end
  end

  task automatic put_slot(input logic lr, input logic d);
    @(negedge clk);
    lrck = lr; sd = d;
    repeat (H) @(negedge clk);
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  function automatic logic val_at(input logic [1:0] f, input int s, input int p, input logic [23:0] w);
    int b;
    b = s - 1 - p;
    if (f[1]) return (b >= 0 && b < 24) ? w[b] : 1'b0;
    return (p >= 0 && p < 24) ? w[23-p] : 1'b0;
  endfunction

  task automatic send_half(input logic [1:0] f, input bit left, input int s, input logic [23:0] w);
    logic lr;
    lr = (f == 2'b01) ? ~left : left;
    for (int p = 0; p < s; p++) begin
      logic d;
      if (f == 2'b01) d = (p == 0) ? pend : val_at(f, s, p - 1, w);
      else            d = val_at(f, s, p, w);
      put_slot(lr, d);
    end
    if (f == 2'b01) pend = val_at(f, s, s - 1, w);
  endtask

  function automatic logic [23:0] exp_word(input logic [1:0] f, input logic [1:0] r, input int s, input logic [23:0] w);
    int k, n;
    logic [23:0] m;
    m = '0;
    if (!f[1]) begin
      k = (s < 24) ? s : 24;
      for (int i = 0; i < k; i++) m[23-i] = 1'b1;
      return w & m;
    end
    n = (r == 2'd0) ? 16 : (r == 2'd1) ? 20 : 24;
    k = (s < n) ? s : n;
    for (int i = 0; i < k; i++) m[i] = 1'b1;
    return (w & m) << (24 - n);
  endfunction

  task automatic burst(input logic [1:0] f, input logic [1:0] r, input int s, input int nfr,
                       input bit pre_left, input string tag);
    @(negedge clk);
    rst_ni = 1'b0; fmt = f; resv = r; sck = 1'b0; lrck = 1'b0; sd = 1'b0; pend = 1'b0;
    repeat (4) @(negedge clk);
    check(left_o == '0 && right_o == '0 && valid_o == 1'b0, "R1 reset state",
          {left_o, right_o}, 48'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    if (pre_left) begin
      // partial first half-frame plus an unpaired right word: nothing expected (R9)
      send_half(f, 1'b1, s, 24'h5A5A5A);
      send_half(f, 1'b0, s, 24'h0F0F0F);
    end else begin
      send_half(f, 1'b0, s, 24'h123456);
    end
    for (int i = 0; i < nfr; i++) begin
      logic [23:0] wl, wr;
      wl = 24'hA5C3F1 ^ (24'h13579B * 24'(i + 1));
      wr = 24'h3CF00F ^ (24'h2468AD * 24'(i + 3));
      q_l.push_back(exp_word(f, r, s, wl));
      q_r.push_back(exp_word(f, r, s, wr));
      q_tag.push_back(tag);
      send_half(f, 1'b1, s, wl);
      send_half(f, 1'b0, s, wr);
    end
    send_half(f, 1'b1, 4, 24'h0);
    repeat (40) @(negedge clk);
    check(q_l.size() == 0, {tag, " pairs delivered"}, 48'(q_l.size()), 48'd0);
    q_l.delete(); q_r.delete(); q_tag.delete();
  endtask

  initial begin
    burst(2'b00, 2'd0, 32, 3, 1'b0, "R2 R4 left-justified 32-slot");
    burst(2'b01, 2'd0, 32, 3, 1'b0, "R3 R4 I2S 32-slot");
    burst(2'b01, 2'd0, 24, 2, 1'b0, "R3 I2S 24-slot");
    burst(2'b00, 2'd0, 20, 2, 1'b0, "R5 left-justified short 20");
    burst(2'b01, 2'd0, 16, 2, 1'b0, "R5 I2S short 16");
    burst(2'b10, 2'd0, 32, 2, 1'b0, "R6 right-justified 16-bit");
    burst(2'b10, 2'd1, 32, 2, 1'b0, "R6 right-justified 20-bit");
    burst(2'b11, 2'd2, 32, 2, 1'b0, "R6 right-justified 24-bit");
    burst(2'b10, 2'd2, 20, 2, 1'b0, "R7 right-justified 24-bit short 20");
    burst(2'b10, 2'd0, 12, 2, 1'b0, "R7 right-justified 16-bit short 12");
    burst(2'b00, 2'd0, 32, 2, 1'b1, "R9 left-justified partial start");
    burst(2'b01, 2'd0, 32, 2, 1'b1, "R9 I2S partial start");
    check(hold_bad == 0, "R8 outputs held between pulses", 48'(hold_bad), 48'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule